// File: doc/BRIEF.md
# Half-Word Masked GPIO Register Bank

This block is the register side of a 32-pin general-purpose I/O bank. Each 32-bit logical setting (output levels, pin direction, and six interrupt configuration fields) is reached as two 16-bit halves at neighbouring word addresses. The lower half covers pins 0 to 15 and the upper half covers pins 16 to 31. Every write carries its own per-bit write enables in the top 16 bits of the data word. Software can therefore set or clear any group of pins in a single write, with no read-modify-write sequence and no race against another agent that changes other bits.

The bank drives the pin output and output-enable vectors directly. It presents the interrupt configuration to a separate edge/level detector. It also reads back that detector's raw and masked status and the detector's end-of-interrupt clear strobes. Pin inputs pass through a synchronizer before software can read them. Reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `gpio_hilo_bank`

## Requirements
- R1: After reset every writable field is zero, so `pin_oe`, `pin_out` and all six interrupt configuration outputs are 0 and every pin is an input.
- R2: On a write, data bit n (0..15) is stored only when bit 16+n of the write word is 1. Bits whose enable is 0 keep their previous value.
- R3: The half at a field's base byte offset holds pins 0..15. The half at base+4 holds pins 16..31. A write to one half never changes the other half.
- R4: A read places the 16 bits of the addressed half in `bus_rdata[15:0]` and returns 0 in `bus_rdata[31:16]`.
- R5: The byte offsets of the field bases are fixed as follows. Writable fields: pin output levels 0x00, direction 0x08, interrupt enable 0x10, interrupt mask 0x18, edge-versus-level select 0x20, polarity 0x28, any-edge select 0x30, debounce enable 0x38. Read-only fields: masked status 0x50, raw status 0x58, pin levels 0x70. End-of-interrupt is at 0x60 and is write-only.
- R6: `pin_oe` always equals the direction field, where 1 means the pin is driven and 0 means it is an input. `pin_out` always equals the output level field.
- R7: The pin-level field returns `pin_in` after two clock stages of synchronization, whatever the direction setting. A level applied before two rising edges is visible in the read after the second edge.
- R8: The masked-status and raw-status halves return the corresponding halves of `irq_status` and `irq_raw`.
- R9: During a write to the end-of-interrupt halves, `eoi_clr` pulses, in the same cycle, the pins whose data bit and enable bit are both 1, placed in that half's pin range. At all other times `eoi_clr` is 0, and reading the end-of-interrupt offset returns 0.
- R10: Any offset not listed in R5 reads as 0 and ignores writes. This includes addresses whose two low bits are not zero.
- R11: The outputs `irq_en`, `irq_mask`, `irq_edge`, `irq_pol`, `irq_any_edge` and `deb_en` each equal their stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write enables [31:16] and data [15:0] |
| bus_rdata | output | 32 | Read data, addressed half in [15:0] |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |
| irq_en | output | 32 | Interrupt enable per pin |
| irq_mask | output | 32 | Interrupt mask per pin |
| irq_edge | output | 32 | 1 = edge triggered, 0 = level |
| irq_pol | output | 32 | Trigger polarity per pin |
| irq_any_edge | output | 32 | Trigger on both edges per pin |
| deb_en | output | 32 | Debounce enable per pin |
| irq_status | input | 32 | Masked status from the detector |
| irq_raw | input | 32 | Raw status from the detector |
| eoi_clr | output | 32 | End-of-interrupt clear pulses |

## Verification
The bench targets partial enables. A design that ignores the enable half would wipe neighbouring pins, and one that applies the enables to the wrong half would move bits across the pin-16 boundary. Misaligned and unlisted offsets are exercised as well, because a decoder that drops the low address bits or the upper group bits would alias them onto live fields. The bench also checks the pin-level read with the pin set as an output and two cycles after a change, so that a missing or extra synchronizer stage shows up. End-of-interrupt writes with enables but zero data catch a clear pulse that was generated from the enables alone.

// File: rtl/gpio_hilo_bank.sv
module gpio_hilo_bank #(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  output logic [31:0]       irq_en,
  output logic [31:0]       irq_mask,
  output logic [31:0]       irq_edge,
  output logic [31:0]       irq_pol,
  output logic [31:0]       irq_any_edge,
  output logic [31:0]       deb_en,
  input  logic [31:0]       irq_status,
  input  logic [31:0]       irq_raw,
  output logic [31:0]       eoi_clr
);
  localparam int NCFG = 8;
  localparam int GW = ADDR_W - 3;
  localparam logic [GW-1:0] G_STAT = GW'(10);
  localparam logic [GW-1:0] G_RAW  = GW'(11);
  localparam logic [GW-1:0] G_EOI  = GW'(12);
  localparam logic [GW-1:0] G_EXT  = GW'(14);

  logic          aligned, hi, cfg_hit;
  logic [GW-1:0] grp;
  logic [31:0]   wmask, wval, sel;
  logic [31:0]   cfg [NCFG];
  logic [31:0]   sync_q [SYNC_STAGES];

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign hi      = bus_addr[2];
  assign grp     = bus_addr[ADDR_W-1:3];
  assign cfg_hit = aligned && (grp < GW'(NCFG));
  assign wmask   = hi ? {bus_wdata[31:16], 16'h0} : {16'h0, bus_wdata[31:16]};
  assign wval    = hi ? {bus_wdata[15:0], 16'h0}  : {16'h0, bus_wdata[15:0]};

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[g] <= '0;
      else if (bus_wr && cfg_hit && grp == GW'(g))
        cfg[g] <= (cfg[g] & ~wmask) | (wval & wmask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_comb begin
    sel = '0;
    if (cfg_hit)
      sel = cfg[grp[2:0]];
    else if (aligned) begin
      case (grp)
        G_STAT:  sel = irq_status;
        G_RAW:   sel = irq_raw;
        G_EXT:   sel = sync_q[SYNC_STAGES-1];
        default: sel = '0;
      endcase
    end
  end

  assign bus_rdata = {16'h0, hi ? sel[31:16] : sel[15:0]};
  assign eoi_clr   = (bus_wr && aligned && grp == G_EOI) ? (wval & wmask) : '0;

  assign pin_out      = cfg[0];
  assign pin_oe       = cfg[1];
  assign irq_en       = cfg[2];
  assign irq_mask     = cfg[3];
  assign irq_edge     = cfg[4];
  assign irq_pol      = cfg[5];
  assign irq_any_edge = cfg[6];
  assign deb_en       = cfg[7];

  assert_masked_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=>
      (((pin_out[15:0] ^ $past(pin_out[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0));

  assert_other_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4)) |=> $stable(pin_out[15:0]));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0);

  assert_eoi_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr != '0) |-> bus_wr);

  assert_misaligned_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1:0] != 2'b00) |=>
      ($stable(pin_out) && $stable(pin_oe) && $stable(irq_en) && $stable(deb_en)));
endmodule

// File: tb/sim_gpio_hilo_bank.sv
module sim_gpio_hilo_bank;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, pin_in = 0, irq_status = 0, irq_raw = 0;
  logic [31:0] bus_rdata, pin_out, pin_oe, irq_en, irq_mask, irq_edge, irq_pol;
  logic [31:0] irq_any_edge, deb_en, eoi_clr;
  int n_tests = 0, n_fail = 0;
  logic [31:0] m [8];
  logic [31:0] s1 = 0, s2 = 0;

  always #2 clk = ~clk;

  gpio_hilo_bank u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_en(irq_en), .irq_mask(irq_mask), .irq_edge(irq_edge),
    .irq_pol(irq_pol), .irq_any_edge(irq_any_edge), .deb_en(deb_en),
    .irq_status(irq_status), .irq_raw(irq_raw), .eoi_clr(eoi_clr));

  // two-stage view of the pins per R7
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin s1 <= 0; s2 <= 0; end
    else begin s1 <= pin_in; s2 <= s1; end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] v = 0;
    if (a[1:0] == 0) begin
      if (a < 8'h40) v = m[a[5:3]];
      else if (a[7:3] == 10) v = irq_status;
      else if (a[7:3] == 11) v = irq_raw;
      else if (a[7:3] == 14) v = s2;
    end
    return {16'h0, a[2] ? v[31:16] : v[15:0]};
  endfunction

  function automatic logic [31:0] exp_eoi(input logic [7:0] a, input logic [31:0] d);
    logic [15:0] b = d[31:16] & d[15:0];
    if (a[1:0] != 0 || a[7:3] != 12) return 0;
    return a[2] ? {b, 16'h0} : {16'h0, b};
  endfunction

  task automatic chk_outs(input string tag);
    chk(pin_out == m[0], {tag, " R6 pin_out"}, pin_out, m[0]);
    chk(pin_oe == m[1], {tag, " R6 pin_oe"}, pin_oe, m[1]);
    chk(irq_en == m[2] && irq_mask == m[3] && irq_edge == m[4], {tag, " R11 en/mask/edge"},
        irq_en ^ irq_mask ^ irq_edge, m[2] ^ m[3] ^ m[4]);
    chk(irq_pol == m[5] && irq_any_edge == m[6] && deb_en == m[7], {tag, " R11 pol/any/deb"},
        irq_pol ^ irq_any_edge ^ deb_en, m[5] ^ m[6] ^ m[7]);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [31:0] mk, vl;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    #1 chk(eoi_clr == exp_eoi(a, d), {tag, " R9 eoi_clr"}, eoi_clr, exp_eoi(a, d));
    @(negedge clk);
    bus_wr = 0;
    if (a[1:0] == 0 && a < 8'h40) begin
      mk = a[2] ? {d[31:16], 16'h0} : {16'h0, d[31:16]};
      vl = a[2] ? {d[15:0], 16'h0} : {16'h0, d[15:0]};
      m[a[5:3]] = (m[a[5:3]] & ~mk) | (vl & mk);
    end
    #1 chk_outs(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 0;
    #1 chk(bus_rdata == exp_read(a), {tag, " R4/R5 read"}, bus_rdata, exp_read(a));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] addrs [24];
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk_outs("R1 reset");

    wr(8'h00, 32'hFFFF_A5A5, "R2 full");
    wr(8'h00, 32'h00FF_FFFF, "R2 partial");
    chk(pin_out == 32'h0000_A5FF, "R2 value", pin_out, 32'h0000_A5FF);
    wr(8'h04, 32'hFFFF_1234, "R3 high");
    chk(pin_out == 32'h1234_A5FF, "R3 value", pin_out, 32'h1234_A5FF);
    rd(8'h04, "R4 high read");
    chk(bus_rdata == 32'h0000_1234, "R4 value", bus_rdata, 32'h0000_1234);
    wr(8'h08, 32'h0F0F_FFFF, "R6 dir");
    chk(pin_oe == 32'h0000_0F0F, "R6 oe value", pin_oe, 32'h0000_0F0F);
    wr(8'h44, 32'hFFFF_FFFF, "R10 unmapped");
    rd(8'h44, "R10 unmapped read");
    wr(8'h01, 32'hFFFF_0000, "R10 misaligned");
    chk(pin_out == 32'h1234_A5FF, "R10 misaligned kept", pin_out, 32'h1234_A5FF);
    wr(8'h60, 32'hFFFF_0000, "R9 eoi zero data");
    wr(8'h64, 32'h00F0_00FF, "R9 eoi high");
    rd(8'h60, "R9 eoi reads zero");
    chk(bus_rdata == 0, "R9 eoi read value", bus_rdata, 0);

    wr(8'h0C, 32'hFFFF_FFFF, "R7 all outputs");
    @(negedge clk); pin_in = 32'hC3C3_5A5A;
    rd(8'h70, "R7 one stage");
    rd(8'h70, "R7 two stages");
    chk(bus_rdata == 32'h0000_5A5A, "R7 value", bus_rdata, 32'h0000_5A5A);
    rd(8'h74, "R7 high");

    irq_status = 32'hDEAD_BEEF; irq_raw = 32'hFACE_0123;
    rd(8'h50, "R8 status lo"); rd(8'h54, "R8 status hi");
    rd(8'h58, "R8 raw lo");    rd(8'h5C, "R8 raw hi");
    chk(bus_rdata == 32'h0000_FACE, "R8 raw hi value", bus_rdata, 32'h0000_FACE);

    for (int i = 0; i < 16; i++) addrs[i] = 8'(i * 4);
    addrs[16] = 8'h50; addrs[17] = 8'h58; addrs[18] = 8'h60; addrs[19] = 8'h74;
    addrs[20] = 8'h40; addrs[21] = 8'h7C; addrs[22] = 8'h13; addrs[23] = 8'h80;
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a = addrs[$urandom_range(0, 23)];
      if (($urandom & 3) == 0) pin_in = $urandom;
      if ($urandom & 1) wr(a, $urandom, "R2/R3/R5 random write");
      else rd(a, "R5 random read");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule